// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Coherent Seconds Snapshot

This block keeps wall time as two free-running counts: a millisecond count that runs from 0 to 999, and a 32-bit seconds count that advances each time the millisecond count wraps. A single-cycle enable, `ms_tick`, marks each elapsed millisecond. It is normally driven from a divided always-on clock, so the counts keep advancing while the rest of the system is suspended. Software reaches the counts over a simple word-addressed register bus with separate read and write strobes.

A timestamp comes from two separate bus reads, and a counter can roll over between them. To handle this, reading the milliseconds register also copies the live seconds value from the same clock edge into a snapshot register. Software reads milliseconds first and the snapshot second. It then forms `snapshot * 1000 + milliseconds`, which is a consistent value even when the seconds count has moved on in between. Writing the live seconds register sets the time and restarts the current second.

Top module: `rtc_ms_shadow`

## Requirements
- R1: After reset, the live seconds, the milliseconds and the snapshot all read as zero, and `rdata` is zero.
- R2: On each clock with `ms_tick` high, the milliseconds count increases by one. With `ms_tick` low and no seconds write, neither count changes.
- R3: When `ms_tick` is high and the milliseconds count is 999, the milliseconds count becomes 0 and the seconds count increases by one at the same edge.
- R4: The seconds count is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R5: A write to offset 0x08 loads the seconds count with `wdata` and clears the milliseconds count to 0. This takes precedence over a tick in the same cycle.
- R6: A read of offset 0x10 returns the milliseconds count, zero-extended. At the same edge it loads the snapshot with the seconds value that was live at that edge, so a wrap happening on that edge is not included.
- R7: A read of offset 0x0c returns the snapshot and leaves it unchanged. Only a read of 0x10 changes the snapshot.
- R8: A read of offset 0x08 returns the live seconds count.
- R9: Writes to 0x0c, 0x10 or any unmapped offset change no state. Reads of unmapped offsets return 0.
- R10: `rdata` is registered. It shows the read result in the cycle after `rd_en` and keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-millisecond advance enable |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench reads milliseconds on the exact edge where 999 wraps to 0. A design that captured the seconds after the update would return a pair one full second ahead of the true time. It also reads the snapshot after the live seconds have advanced, and reads it repeatedly. A design that updated the snapshot on a snapshot read, or tracked live seconds, would return a newer value. It loads 0xFFFFFFFF and crosses the wrap, and it writes the seconds with a tick in the same cycle. These cases expose a saturating counter, or a tick that wins over the write. Writes to the read-only and unmapped offsets are followed by reads of every register, to catch any decode that leaks into state.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Register byte offsets; software relies on these positions.
    localparam int unsigned OFF_SEC_LIVE = 32'h08;
    localparam int unsigned OFF_SEC_SNAP = 32'h0c;
    localparam int unsigned OFF_MSEC     = 32'h10;

    // One-hot register select produced by the address decoder.
    typedef struct packed {
        logic sec_live;
        logic sec_snap;
        logic msec;
    } rtc_sel_t;

endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
    parameter int unsigned MS_PER_SEC = 1000,
    parameter int unsigned MS_W       = $clog2(MS_PER_SEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clear,
    output logic [MS_W-1:0] ms,
    output logic            carry
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    typedef struct packed {
        logic [MS_W-1:0] ms;
    } ms_state_t;

    ms_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        carry   = 1'b0;
        if (clear) begin
            state_d.ms = '0;
        end else if (tick) begin
            if (state_q.ms == MS_LAST) begin
                state_d.ms = '0;
                carry      = 1'b1;
            end else begin
                state_d.ms = state_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ms = state_q.ms;

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int unsigned SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic             inc,
    output logic [SEC_W-1:0] sec
);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } sec_state_t;

    sec_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.sec = load_val;
        end else if (inc) begin
            state_d.sec = state_q.sec + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec = state_q.sec;

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned MS_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEC_W-1:0]  sec,
    input  logic [MS_W-1:0]   ms,
    output logic              sec_load,
    output logic              ms_read,
    output logic [SEC_W-1:0]  shadow,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [SEC_W-1:0]  shadow;
        logic [DATA_W-1:0] rdata;
    } regif_state_t;

    regif_state_t state_d, state_q;
    rtc_sel_t     sel;

    always_comb begin
        sel.sec_live = (addr == ADDR_W'(OFF_SEC_LIVE));
        sel.sec_snap = (addr == ADDR_W'(OFF_SEC_SNAP));
        sel.msec     = (addr == ADDR_W'(OFF_MSEC));
    end

    assign sec_load = wr_en && sel.sec_live;
    assign ms_read  = rd_en && sel.msec;

    always_comb begin
        state_d = state_q;
        if (ms_read) begin
            state_d.shadow = sec;
        end
        if (rd_en) begin
            unique case (1'b1)
                sel.sec_live: state_d.rdata = DATA_W'(sec);
                sel.sec_snap: state_d.rdata = DATA_W'(state_q.shadow);
                sel.msec:     state_d.rdata = DATA_W'(ms);
                default:      state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign shadow = state_q.shadow;
    assign rdata  = state_q.rdata;

endmodule

// File: rtl/rtc_ms_shadow.sv
module rtc_ms_shadow #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned MS_PER_SEC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned MS_W = $clog2(MS_PER_SEC);

    logic [MS_W-1:0]  ms_val;
    logic [SEC_W-1:0] sec_val;
    logic [SEC_W-1:0] shadow_val;
    logic             sec_load;
    logic             ms_read;
    logic             ms_carry;

    rtc_ms_counter #(
        .MS_PER_SEC (MS_PER_SEC),
        .MS_W       (MS_W)
    ) i_ms (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .clear (sec_load),
        .ms    (ms_val),
        .carry (ms_carry)
    );

    rtc_sec_counter #(
        .SEC_W (SEC_W)
    ) i_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sec_load),
        .load_val (wdata[SEC_W-1:0]),
        .inc      (ms_carry),
        .sec      (sec_val)
    );

    rtc_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEC_W  (SEC_W),
        .MS_W   (MS_W)
    ) i_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .sec      (sec_val),
        .ms       (ms_val),
        .sec_load (sec_load),
        .ms_read  (ms_read),
        .shadow   (shadow_val),
        .rdata    (rdata)
    );

endmodule

// File: rtl/rtc_ms_shadow_chk.sv
module rtc_ms_shadow_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned MS_PER_SEC = 1000,
    parameter int unsigned MS_W       = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              sec_load,
    input logic              ms_read,
    input logic [MS_W-1:0]   ms_val,
    input logic [SEC_W-1:0]  sec_val,
    input logic [SEC_W-1:0]  shadow_val
);

    localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

    p_ms_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ms_val <= LAST);

    p_ms_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !sec_load && ms_val != LAST)
        |=> (ms_val == $past(ms_val) + 1'b1) && $stable(sec_val));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !sec_load) |=> ($stable(ms_val) && $stable(sec_val)));

    p_wrap_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !sec_load && ms_val == LAST)
        |=> (ms_val == '0) && (sec_val == SEC_W'($past(sec_val) + 1'b1)));

    p_sec_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_load |=> (sec_val == $past(wdata[SEC_W-1:0])) && (ms_val == '0));

    p_snap_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ms_read |=> shadow_val == $past(sec_val));

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_read |=> $stable(shadow_val));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind rtc_ms_shadow rtc_ms_shadow_chk #(
    .DATA_W     (DATA_W),
    .SEC_W      (SEC_W),
    .MS_PER_SEC (MS_PER_SEC),
    .MS_W       (MS_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .sec_load   (sec_load),
    .ms_read    (ms_read),
    .ms_val     (ms_val),
    .sec_val    (sec_val),
    .shadow_val (shadow_val)
);

// File: tb/test_rtc_ms_shadow.sv
`timescale 1ns/1ps
module test_rtc_ms_shadow;

    localparam logic [7:0] A_SEC  = 8'h08;
    localparam logic [7:0] A_SNAP = 8'h0c;
    localparam logic [7:0] A_MS   = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model
    logic [31:0] m_sec = '0;
    logic [31:0] m_ms  = '0;
    logic [31:0] m_snap = '0;
    logic [31:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    rtc_ms_shadow i_rtc_ms_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    function automatic logic [31:0] read_value(input logic [7:0] a);
        case (a)
            A_SEC:   return m_sec;
            A_SNAP:  return m_snap;
            A_MS:    return m_ms;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input bit rd, input bit wr, input logic [7:0] a,
                        input logic [31:0] wd, input bit tk, input string req,
                        input bit check_hold);
        logic [31:0] prev_rdata;
        rd_en = rd; wr_en = wr; addr = a; wdata = wd; ms_tick = tk;
        prev_rdata = m_rdata;
        if (rd) m_rdata = read_value(a);
        if (rd && a == A_MS) m_snap = m_sec;
        if (wr && a == A_SEC) begin
            m_sec = wd;
            m_ms  = 0;
        end else if (tk) begin
            if (m_ms == 999) begin
                m_ms  = 0;
                m_sec = m_sec + 1;
            end else begin
                m_ms = m_ms + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; ms_tick = 1'b0;
        if (rd) check(req, rdata, m_rdata);
        else if (check_hold) check("R10", rdata, prev_rdata);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(1'b1, 1'b0, a, 32'h0, 1'b0, req, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R1", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero after reset
        rd(A_SEC, "R1"); rd(A_SNAP, "R1"); rd(A_MS, "R1");

        // R2: counting and holding
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00, 0, 1'b1, "R2", 1'b0);
        step(1'b0, 1'b0, 8'h00, 0, 1'b0, "R2", 1'b0);
        rd(A_MS, "R2");

        // R5: write beats a simultaneous tick
        step(1'b0, 1'b1, A_SEC, 32'd77, 1'b1, "R5", 1'b0);
        rd(A_MS, "R5"); rd(A_SEC, "R5");

        // R3/R6: read milliseconds on the wrapping edge
        for (int i = 0; i < 999; i++) step(1'b0, 1'b0, 8'h00, 0, 1'b1, "R3", 1'b0);
        step(1'b1, 1'b0, A_MS, 0, 1'b1, "R6", 1'b0);
        rd(A_SEC, "R3");
        rd(A_SNAP, "R6");
        rd(A_SNAP, "R7");
        rd(A_MS, "R3");

        // R4: seconds wrap
        step(1'b0, 1'b1, A_SEC, 32'hFFFF_FFFF, 1'b0, "R4", 1'b0);
        for (int i = 0; i < 1000; i++) step(1'b0, 1'b0, 8'h00, 0, 1'b1, "R4", 1'b0);
        rd(A_SEC, "R4");

        // R9: writes to read-only and unmapped offsets change nothing
        step(1'b0, 1'b1, A_MS,   32'h1234, 1'b0, "R9", 1'b0);
        step(1'b0, 1'b1, A_SNAP, 32'h5678, 1'b0, "R9", 1'b0);
        step(1'b0, 1'b1, 8'h14,  32'h9abc, 1'b0, "R9", 1'b0);
        rd(A_MS, "R9"); rd(A_SNAP, "R9"); rd(A_SEC, "R9");
        rd(8'h00, "R9"); rd(8'h14, "R9");

        // R10: rdata holds over idle cycles
        rd(A_SEC, "R8");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'h00, 0, 1'b1, "R10", 1'b1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            int unsigned sel;
            bit r, w;
            sel = $urandom_range(0, 9);
            a = (sel < 3) ? A_MS : (sel < 5) ? A_SNAP : (sel < 8) ? A_SEC :
                (sel == 8) ? 8'h14 : 8'h00;
            r = ($urandom_range(0, 2) == 0);
            w = ($urandom_range(0, 19) == 0);
            step(r, w, a, (w && $urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom,
                 ($urandom_range(0, 9) < 7), "R8", 1'b1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule